// File: doc/BRIEF.md
# AXI Address Firewall with Match Table

This block sits on the outgoing address channels of an AXI master and decides, for every read and write address request, whether it may leave. Each request is compared at the same moment against every entry of a small match table. An entry holds a 58-bit compare address, a 58-bit don't-care mask and, if wanted, a 10-bit master ID. The lowest-numbered matching entry supplies the verdict, which is kept separately for reads and for writes. That entry may also replace the low 46 address bits with a new base and may exchange two configurable address bit positions to interleave across banks. A request that matches no entry follows a miss policy that is set separately for reads and for writes.

Allowed requests pass through in the same cycle, with the protection sideband attached. Denied requests are accepted and dropped. One cycle later the block raises a single-cycle interrupt pulse and latches the dropped address. Software loads entries through a write window of six 32-bit words, with the last word committing the entry. It reads entries back through a read window of six words selected by an index register. A parameter chooses between a privileged configuration and a guest configuration. The privileged one denies misses by default and drives protection bits. The guest one passes misses by default and drives zero protection.

Top module: `axi_addr_fw`

## Requirements
- R1: An entry matches a request when its valid bit is 1, when ((request address XOR compare address) AND NOT mask) is zero over all 58 bits (mask bit 1 = don't care), and when either its ID-compare-disable bit is 1 or the 10-bit request ID equals the entry ID.
- R2: When more than one entry matches, the entry with the lowest index supplies the verdict and the rewrite.
- R3: On a match, a read is allowed when the entry's read-pass bit is 1 and a write when its write-pass bit is 1. An allowed request shows up on the forwarding side in the same cycle with the same ID, and the request-side ready follows the forwarding-side ready.
- R4: When the matching entry has remap enabled, forwarded address bits [45:0] equal the entry's 46-bit remap address and bits [57:46] equal the request's bits.
- R5: When the matching entry has interleave enabled, the bits at the two positions held in the swap register (word 2, first position in [5:0], second in [13:8]) are exchanged after any remap. A position of 58 or above leaves the address unchanged.
- R6: A request that matches no entry is allowed when the miss policy bit of its direction is 1 (word 0: bit 0 for writes, bit 1 for reads). Both bits reset to 0 in the privileged configuration and to 1 in the guest configuration.
- R7: Writing a 7-bit index to word 3 makes words 4..9 show that entry. Word 5 holds valid[31], write-pass[30], read-pass[29], ID-compare-disable[28], interleave[27], remap[26] and compare address [57:32] in [25:0]. Words 4/6/8 hold compare[31:0], mask[31:0] and remap[31:0]. Word 7 holds mask[57:32] in [25:0]. Word 9 holds the ID in [25:16] and remap[45:32] in [13:0]. An index at or above the table depth reads as zero.
- R8: Words 10..14 buffer the entry using the layout of words 4..8. A write to word 15 with the index in [31:24], the ID in [23:14] and remap[45:32] in [13:0] commits the entry. A commit with an index at or above the depth has no effect.
- R9: After reset or clear, every entry is invalid with all fields zero, except ID-compare-disable, which is 0 in the privileged and 1 in the guest configuration.
- R10: In the privileged configuration, word 1 holds the read protection value in [6:4] and the write protection value in [2:0]. Both reset to 3'b010 and drive the forwarded read and write requests. In the guest configuration both outputs are 0, word 1 reads 0 and writes to it are ignored.
- R11: A denied request is accepted (request-side ready is 1) and not forwarded. In the next cycle the interrupt is 1 for one cycle and the latch holds the denied address. If both directions are denied in the same cycle, the read address is latched.
- R12: A clear pulse returns every entry to its reset state in one cycle. The miss policy, protection and swap registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tableClr | input | 1 | Returns all entries to reset state |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| arReqValid | input | 1 | Read request valid |
| arReqReady | output | 1 | Read request ready |
| arReqAddr | input | 58 | Read request address |
| arReqId | input | 10 | Read request master ID |
| arFwdValid | output | 1 | Forwarded read valid |
| arFwdReady | input | 1 | Forwarded read ready |
| arFwdAddr | output | 58 | Forwarded read address |
| arFwdId | output | 10 | Forwarded read ID |
| arFwdProt | output | 3 | Forwarded read protection |
| awReqValid | input | 1 | Write request valid |
| awReqReady | output | 1 | Write request ready |
| awReqAddr | input | 58 | Write request address |
| awReqId | input | 10 | Write request master ID |
| awFwdValid | output | 1 | Forwarded write valid |
| awFwdReady | input | 1 | Forwarded write ready |
| awFwdAddr | output | 58 | Forwarded write address |
| awFwdId | output | 10 | Forwarded write ID |
| awFwdProt | output | 3 | Forwarded write protection |
| denyIrq | output | 1 | One-cycle pulse after a denial |
| denyAddr | output | 58 | Address of the latest denied request |

## Verification
The hardest case to reach from the ports is a request that matches two programmed entries whose verdicts disagree, combined with an entry that both remaps and swaps a bit lying in the untouched upper field. The stimulus builds this up in steps. It first programs a narrow ID-qualified entry at index 2 and then a wider ID-agnostic entry at index 1 covering the same region, so the same read flips from allowed to denied. It then sets up index 0 to remap and swap position 57 with position 0. A behavioural model in the bench recomputes every output each cycle and compares it, and this includes a cycle where both directions are denied at once.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int ADDR_W   = 58;
  localparam int ID_W     = 10;
  localparam int RMP_W    = 46;
  localparam int POS_W    = 6;
  localparam int HI_W     = ADDR_W - 32;
  localparam int RMP_HI_W = RMP_W - 32;

  // register word addresses
  localparam logic [3:0] REG_MISS = 4'd0;
  localparam logic [3:0] REG_PROT = 4'd1;
  localparam logic [3:0] REG_SWAP = 4'd2;
  localparam logic [3:0] REG_RIDX = 4'd3;
  localparam logic [3:0] REG_RD0  = 4'd4;
  localparam logic [3:0] REG_WR0  = 4'd10;
  localparam logic [3:0] REG_WR5  = 4'd15;

  typedef struct packed {
    logic              valid;
    logic              wrPass;
    logic              rdPass;
    logic              idCmpDis;
    logic              intlvEn;
    logic              remapEn;
    logic [ADDR_W-1:0] cmpAddr;
    logic [ADDR_W-1:0] cmpMask;
    logic [RMP_W-1:0]  remapAddr;
    logic [ID_W-1:0]   id;
  } fwEntry_t;

  // strobes from the lookup datapath back to control
  typedef struct packed {
    logic rdDeny;
    logic wrDeny;
  } fwStrobe_t;
endpackage

// File: rtl/fw_ctrl.sv
module fw_ctrl
  import fw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit PRIV  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tableClr,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  fwStrobe_t         evt,
  input  logic [ADDR_W-1:0] rdReqAddr,
  input  logic [ADDR_W-1:0] wrReqAddr,
  output fwEntry_t          entries [DEPTH],
  output logic              rdMissPass,
  output logic              wrMissPass,
  output logic [POS_W-1:0]  swapA,
  output logic [POS_W-1:0]  swapB,
  output logic [2:0]        arProt,
  output logic [2:0]        awProt,
  output logic              denyIrq,
  output logic [ADDR_W-1:0] denyAddr
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [6:0]  rdIdx;
  logic [31:0] wrBuf [5];
  fwEntry_t    entryRst;
  fwEntry_t    newEntry;
  fwEntry_t    selEnt;
  logic        commit;
  logic        commitInRange;
  logic        anyValid;

  always_comb begin
    entryRst          = '0;
    entryRst.idCmpDis = (PRIV == 1'b0);
  end

  always_comb begin
    newEntry.valid     = wrBuf[1][31];
    newEntry.wrPass    = wrBuf[1][30];
    newEntry.rdPass    = wrBuf[1][29];
    newEntry.idCmpDis  = wrBuf[1][28];
    newEntry.intlvEn   = wrBuf[1][27];
    newEntry.remapEn   = wrBuf[1][26];
    newEntry.cmpAddr   = {wrBuf[1][HI_W-1:0], wrBuf[0]};
    newEntry.cmpMask   = {wrBuf[3][HI_W-1:0], wrBuf[2]};
    newEntry.remapAddr = {regWdata[RMP_HI_W-1:0], wrBuf[4]};
    newEntry.id        = regWdata[23:14];
  end

  assign commit        = regWe && (regAddr == REG_WR5);
  assign commitInRange = ({24'b0, regWdata[31:24]} < 32'(DEPTH));

  // entry storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) entries[i] <= entryRst;
    end else if (tableClr) begin
      for (int i = 0; i < DEPTH; i++) entries[i] <= entryRst;
    end else if (commit && commitInRange) begin
      entries[regWdata[IDX_W+23:24]] <= newEntry;
    end
  end

  // configuration and staging registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdMissPass <= (PRIV == 1'b0);
      wrMissPass <= (PRIV == 1'b0);
      swapA      <= '0;
      swapB      <= '0;
      rdIdx      <= '0;
      for (int b = 0; b < 5; b++) wrBuf[b] <= '0;
    end else if (regWe) begin
      case (regAddr)
        REG_MISS: {rdMissPass, wrMissPass} <= regWdata[1:0];
        REG_SWAP: begin
          swapB <= regWdata[13:8];
          swapA <= regWdata[5:0];
        end
        REG_RIDX: rdIdx <= regWdata[6:0];
        4'd10:    wrBuf[0] <= regWdata;
        4'd11:    wrBuf[1] <= regWdata;
        4'd12:    wrBuf[2] <= regWdata;
        4'd13:    wrBuf[3] <= regWdata;
        4'd14:    wrBuf[4] <= regWdata;
        default: ;
      endcase
    end
  end

  generate
    if (PRIV) begin : g_prot
      logic [2:0] arProtQ, awProtQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          arProtQ <= 3'b010;
          awProtQ <= 3'b010;
        end else if (regWe && regAddr == REG_PROT) begin
          arProtQ <= regWdata[6:4];
          awProtQ <= regWdata[2:0];
        end
      end
      assign arProt = arProtQ;
      assign awProt = awProtQ;

      // R10: protection only moves on a register write
      a_r10_prot_hold: assert property (@(posedge clk) disable iff (!rstN)
        !$past(regWe) |-> ($stable(arProt) && $stable(awProt)));
    end else begin : g_noprot
      assign arProt = 3'b000;
      assign awProt = 3'b000;
    end
  endgenerate

  // read window
  always_comb begin
    selEnt = ({25'b0, rdIdx} < 32'(DEPTH)) ? entries[rdIdx[IDX_W-1:0]] : '0;
  end

  always_comb begin
    case (regAddr)
      REG_MISS: regRdata = {30'b0, rdMissPass, wrMissPass};
      REG_PROT: regRdata = {25'b0, arProt, 1'b0, awProt};
      REG_SWAP: regRdata = {18'b0, swapB, 2'b0, swapA};
      REG_RIDX: regRdata = {25'b0, rdIdx};
      REG_RD0:  regRdata = selEnt.cmpAddr[31:0];
      4'd5:     regRdata = {selEnt.valid, selEnt.wrPass, selEnt.rdPass, selEnt.idCmpDis,
                            selEnt.intlvEn, selEnt.remapEn, selEnt.cmpAddr[ADDR_W-1:32]};
      4'd6:     regRdata = selEnt.cmpMask[31:0];
      4'd7:     regRdata = {6'b0, selEnt.cmpMask[ADDR_W-1:32]};
      4'd8:     regRdata = selEnt.remapAddr[31:0];
      4'd9:     regRdata = {6'b0, selEnt.id, 2'b0, selEnt.remapAddr[RMP_W-1:32]};
      default:  regRdata = '0;
    endcase
  end

  // deny interrupt and address latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      denyIrq  <= 1'b0;
      denyAddr <= '0;
    end else begin
      denyIrq <= evt.rdDeny | evt.wrDeny;
      if (evt.rdDeny)      denyAddr <= rdReqAddr;
      else if (evt.wrDeny) denyAddr <= wrReqAddr;
    end
  end

  always_comb begin
    anyValid = 1'b0;
    for (int i = 0; i < DEPTH; i++) anyValid = anyValid | entries[i].valid;
  end

  // R11: the pulse always has a datapath denial behind it
  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    denyIrq |-> $past(evt.rdDeny || evt.wrDeny));
  // R11: latch keeps its value without a denial
  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(evt.rdDeny || evt.wrDeny) |-> $stable(denyAddr));
  // R12: a clear leaves no valid entry
  a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    $past(tableClr) |-> !anyValid);
endmodule

// File: rtl/fw_lookup.sv
module fw_lookup
  import fw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit IS_WR = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwEntry_t          entries [DEPTH],
  input  logic              missPass,
  input  logic [POS_W-1:0]  swapA,
  input  logic [POS_W-1:0]  swapB,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [ID_W-1:0]   inId,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic [ID_W-1:0]   outId,
  output logic              deny
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] matchVec;
  logic             hit;
  logic [IDX_W-1:0] hitIdx;
  fwEntry_t         hitEnt;
  logic             allow;
  logic [ADDR_W-1:0] remapped;
  logic [ADDR_W-1:0] swapped;
  logic             swapOk;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_match
      assign matchVec[g] = entries[g].valid
        && (((inAddr ^ entries[g].cmpAddr) & ~entries[g].cmpMask) == '0)
        && (entries[g].idCmpDis || (inId == entries[g].id));
    end
  endgenerate

  // lowest index wins
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign hitEnt = entries[hitIdx];
  assign allow  = hit ? (IS_WR ? hitEnt.wrPass : hitEnt.rdPass) : missPass;
  assign swapOk = (swapA < 6'(ADDR_W)) && (swapB < 6'(ADDR_W));

  always_comb begin
    remapped = inAddr;
    if (hit && hitEnt.remapEn) remapped[RMP_W-1:0] = hitEnt.remapAddr;
    swapped = remapped;
    if (hit && hitEnt.intlvEn && swapOk) begin
      swapped[swapA] = remapped[swapB];
      swapped[swapB] = remapped[swapA];
    end
  end

  assign outAddr  = swapped;
  assign outId    = inId;
  assign outValid = inValid & allow;
  assign inReady  = allow ? outReady : 1'b1;
  assign deny     = inValid & ~allow;

  // R11: a denied request is taken and not forwarded
  a_r11_deny_consumes: assert property (@(posedge clk) disable iff (!rstN)
    deny |-> (inReady && !outValid));
  // R3: nothing is forwarded without a request, and the ID rides along
  a_r3_fwd_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inValid && outId == inId));
  // R4: the rewrite never reaches the upper field unless a swap points there
  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && swapA < 6'd46 && swapB < 6'd46) |-> (outAddr[ADDR_W-1:RMP_W] == inAddr[ADDR_W-1:RMP_W]));
endmodule

// File: rtl/axi_addr_fw.sv
module axi_addr_fw
  import fw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit PRIV  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tableClr,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              arReqValid,
  output logic              arReqReady,
  input  logic [57:0]       arReqAddr,
  input  logic [9:0]        arReqId,
  output logic              arFwdValid,
  input  logic              arFwdReady,
  output logic [57:0]       arFwdAddr,
  output logic [9:0]        arFwdId,
  output logic [2:0]        arFwdProt,
  input  logic              awReqValid,
  output logic              awReqReady,
  input  logic [57:0]       awReqAddr,
  input  logic [9:0]        awReqId,
  output logic              awFwdValid,
  input  logic              awFwdReady,
  output logic [57:0]       awFwdAddr,
  output logic [9:0]        awFwdId,
  output logic [2:0]        awFwdProt,
  output logic              denyIrq,
  output logic [57:0]       denyAddr
);
  fwEntry_t         entries [DEPTH];
  fwStrobe_t        evt;
  logic             rdMissPass, wrMissPass;
  logic [POS_W-1:0] swapA, swapB;

  fw_ctrl #(.DEPTH(DEPTH), .PRIV(PRIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .tableClr(tableClr),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .evt(evt), .rdReqAddr(arReqAddr), .wrReqAddr(awReqAddr),
    .entries(entries), .rdMissPass(rdMissPass), .wrMissPass(wrMissPass),
    .swapA(swapA), .swapB(swapB), .arProt(arFwdProt), .awProt(awFwdProt),
    .denyIrq(denyIrq), .denyAddr(denyAddr)
  );

  fw_lookup #(.DEPTH(DEPTH), .IS_WR(1'b0)) rdLook_i (
    .clk(clk), .rstN(rstN), .entries(entries), .missPass(rdMissPass),
    .swapA(swapA), .swapB(swapB),
    .inValid(arReqValid), .inReady(arReqReady), .inAddr(arReqAddr), .inId(arReqId),
    .outValid(arFwdValid), .outReady(arFwdReady), .outAddr(arFwdAddr), .outId(arFwdId),
    .deny(evt.rdDeny)
  );

  fw_lookup #(.DEPTH(DEPTH), .IS_WR(1'b1)) wrLook_i (
    .clk(clk), .rstN(rstN), .entries(entries), .missPass(wrMissPass),
    .swapA(swapA), .swapB(swapB),
    .inValid(awReqValid), .inReady(awReqReady), .inAddr(awReqAddr), .inId(awReqId),
    .outValid(awFwdValid), .outReady(awFwdReady), .outAddr(awFwdAddr), .outId(awFwdId),
    .deny(evt.wrDeny)
  );
endmodule

// File: tb/axi_addr_fw_tb_top.sv
`timescale 1ns/1ps
module axi_addr_fw_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, tableClr, regWe;
  logic [3:0] regAddr;
  logic [31:0] regWdata, regRdata;
  logic arReqValid, arReqReady, arFwdValid, arFwdReady;
  logic [57:0] arReqAddr, arFwdAddr;
  logic [9:0] arReqId, arFwdId;
  logic [2:0] arFwdProt;
  logic awReqValid, awReqReady, awFwdValid, awFwdReady;
  logic [57:0] awReqAddr, awFwdAddr;
  logic [9:0] awReqId, awFwdId;
  logic [2:0] awFwdProt;
  logic denyIrq;
  logic [57:0] denyAddr;

  // guest configuration instance
  logic gRegWe;
  logic [3:0] gRegAddr;
  logic [31:0] gRegWdata, gRegRdata;
  logic gArValid, gArReady, gArFwdValid, gAwReady, gAwFwdValid, gIrq;
  logic [57:0] gArFwdAddr, gAwFwdAddr, gDenyAddr;
  logic [9:0] gArFwdId, gAwFwdId;
  logic [2:0] gArProt, gAwProt;

  axi_addr_fw #(.DEPTH(DEPTH), .PRIV(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .tableClr(tableClr), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .arReqValid(arReqValid), .arReqReady(arReqReady), .arReqAddr(arReqAddr), .arReqId(arReqId),
    .arFwdValid(arFwdValid), .arFwdReady(arFwdReady), .arFwdAddr(arFwdAddr), .arFwdId(arFwdId),
    .arFwdProt(arFwdProt),
    .awReqValid(awReqValid), .awReqReady(awReqReady), .awReqAddr(awReqAddr), .awReqId(awReqId),
    .awFwdValid(awFwdValid), .awFwdReady(awFwdReady), .awFwdAddr(awFwdAddr), .awFwdId(awFwdId),
    .awFwdProt(awFwdProt), .denyIrq(denyIrq), .denyAddr(denyAddr));

  axi_addr_fw #(.DEPTH(DEPTH), .PRIV(1'b0)) guest_i (
    .clk(clk), .rstN(rstN), .tableClr(1'b0), .regWe(gRegWe), .regAddr(gRegAddr),
    .regWdata(gRegWdata), .regRdata(gRegRdata),
    .arReqValid(gArValid), .arReqReady(gArReady), .arReqAddr(58'h3_0000_1000), .arReqId(10'h3),
    .arFwdValid(gArFwdValid), .arFwdReady(1'b1), .arFwdAddr(gArFwdAddr), .arFwdId(gArFwdId),
    .arFwdProt(gArProt),
    .awReqValid(1'b0), .awReqReady(gAwReady), .awReqAddr(58'h0), .awReqId(10'h0),
    .awFwdValid(gAwFwdValid), .awFwdReady(1'b1), .awFwdAddr(gAwFwdAddr), .awFwdId(gAwFwdId),
    .awFwdProt(gAwProt), .denyIrq(gIrq), .denyAddr(gDenyAddr));

  // ---------------- behavioural reference model ----------------
  bit mV[DEPTH], mWrP[DEPTH], mRdP[DEPTH], mIdDis[DEPTH], mIntlv[DEPTH], mRmpEn[DEPTH];
  logic [57:0] mCmp[DEPTH], mMask[DEPTH];
  logic [45:0] mRmp[DEPTH];
  logic [9:0]  mId[DEPTH];
  bit mRdMiss, mWrMiss;
  logic [2:0] mArProt, mAwProt;
  logic [5:0] mSa, mSb;
  logic [31:0] mBuf[5];
  bit expIrq;
  logic [57:0] expLatch;

  int nChk = 0, nFail = 0;
  bit running = 0, done = 0;
  string curReq = "R9";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < DEPTH; i++) begin
      mV[i] = 0; mWrP[i] = 0; mRdP[i] = 0; mIdDis[i] = 0; mIntlv[i] = 0; mRmpEn[i] = 0;
      mCmp[i] = '0; mMask[i] = '0; mRmp[i] = '0; mId[i] = '0;
    end
  endtask

  function automatic void mLook(input bit wr, input logic [57:0] a, input logic [9:0] id,
                                output bit allow, output logic [57:0] oa);
    int h = -1;
    logic [57:0] t;
    for (int i = 0; i < DEPTH; i++) begin
      if (mV[i] && (((a ^ mCmp[i]) & ~mMask[i]) == 58'h0) && (mIdDis[i] || id == mId[i])) begin
        h = i;
        break;
      end
    end
    oa = a;
    if (h < 0) begin
      allow = wr ? mWrMiss : mRdMiss;
    end else begin
      allow = wr ? mWrP[h] : mRdP[h];
      if (mRmpEn[h]) oa = {a[57:46], mRmp[h]};
      if (mIntlv[h] && mSa < 58 && mSb < 58) begin
        t = oa;
        oa[mSa] = t[mSb];
        oa[mSb] = t[mSa];
      end
    end
  endfunction

  function automatic logic [31:0] mWord(input int i, input int w);
    if (i >= DEPTH) return 32'h0;
    case (w)
      0: return mCmp[i][31:0];
      1: return {mV[i], mWrP[i], mRdP[i], mIdDis[i], mIntlv[i], mRmpEn[i], mCmp[i][57:32]};
      2: return mMask[i][31:0];
      3: return {6'b0, mMask[i][57:32]};
      4: return mRmp[i][31:0];
      default: return {6'b0, mId[i], 2'b0, mRmp[i][45:32]};
    endcase
  endfunction

  task automatic modelWrite(input logic [3:0] a, input logic [31:0] d);
    int idx;
    case (a)
      4'd0: begin mRdMiss = d[1]; mWrMiss = d[0]; end
      4'd1: begin mArProt = d[6:4]; mAwProt = d[2:0]; end
      4'd2: begin mSb = d[13:8]; mSa = d[5:0]; end
      4'd10, 4'd11, 4'd12, 4'd13, 4'd14: mBuf[a - 4'd10] = d;
      4'd15: begin
        idx = int'(d[31:24]);
        if (idx < DEPTH) begin
          mV[idx] = mBuf[1][31]; mWrP[idx] = mBuf[1][30]; mRdP[idx] = mBuf[1][29];
          mIdDis[idx] = mBuf[1][28]; mIntlv[idx] = mBuf[1][27]; mRmpEn[idx] = mBuf[1][26];
          mCmp[idx] = {mBuf[1][25:0], mBuf[0]};
          mMask[idx] = {mBuf[3][25:0], mBuf[2]};
          mRmp[idx] = {d[13:0], mBuf[4]};
          mId[idx] = d[23:14];
        end
      end
      default: ;
    endcase
  endtask

  // interrupt and latch expectation, evaluated on the same edge as the design
  always @(posedge clk) begin
    bit ar, aw;
    logic [57:0] oa;
    if (!rstN) begin
      expIrq = 0; expLatch = '0;
    end else begin
      mLook(0, arReqAddr, arReqId, ar, oa);
      mLook(1, awReqAddr, awReqId, aw, oa);
      expIrq = (arReqValid && !ar) || (awReqValid && !aw);
      if (arReqValid && !ar) expLatch = arReqAddr;
      else if (awReqValid && !aw) expLatch = awReqAddr;
    end
  end

  // every-cycle comparison of all request-path outputs
  always @(negedge clk) begin
    bit ar, aw;
    logic [57:0] ra, wa;
    logic [255:0] act, exp;
    if (running && rstN) begin
      mLook(0, arReqAddr, arReqId, ar, ra);
      mLook(1, awReqAddr, awReqId, aw, wa);
      exp = {arReqValid && ar, ar ? arFwdReady : 1'b1, (arReqValid && ar) ? ra : 58'h0, arReqId, mArProt,
             awReqValid && aw, aw ? awFwdReady : 1'b1, (awReqValid && aw) ? wa : 58'h0, awReqId, mAwProt,
             expIrq, expLatch};
      act = {arFwdValid, arReqReady, arFwdValid ? arFwdAddr : 58'h0, arFwdId, arFwdProt,
             awFwdValid, awReqReady, awFwdValid ? awFwdAddr : 58'h0, awFwdId, awFwdProt,
             denyIrq, denyAddr};
      chk(act == exp, curReq, "cycle outputs", act, exp);
    end
  end

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1 regWe = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1 regWe = 0; modelWrite(a, d);
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1 regAddr = a;
    @(negedge clk); d = regRdata;
  endtask

  task automatic gRd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1 gRegAddr = a;
    @(negedge clk); d = gRegRdata;
  endtask

  task automatic prog(input int idx, input logic [5:0] fl, input logic [57:0] cmp,
                      input logic [57:0] msk, input logic [45:0] rmp, input logic [9:0] id);
    regWr(4'd10, cmp[31:0]);
    regWr(4'd11, {fl, cmp[57:32]});
    regWr(4'd12, msk[31:0]);
    regWr(4'd13, {6'b0, msk[57:32]});
    regWr(4'd14, rmp[31:0]);
    regWr(4'd15, {idx[7:0], id, rmp[45:32]});
  endtask

  task automatic ar(input bit v, input logic [57:0] a, input logic [9:0] id, input int n);
    @(posedge clk); #1 arReqValid = v; arReqAddr = a; arReqId = id;
    repeat (n) @(posedge clk);
    #1 arReqValid = 0;
  endtask

  task automatic aw(input bit v, input logic [57:0] a, input logic [9:0] id, input int n);
    @(posedge clk); #1 awReqValid = v; awReqAddr = a; awReqId = id;
    repeat (n) @(posedge clk);
    #1 awReqValid = 0;
  endtask

  task automatic readEntry(input int idx, input string req);
    logic [31:0] d;
    regWr(4'd3, idx);
    for (int w = 0; w < 6; w++) begin
      regRd(4'(4 + w), d);
      chk(d == mWord(idx, w), req, "entry word", {224'h0, d}, {224'h0, mWord(idx, w)});
    end
  endtask

  localparam logic [57:0] HIT_A = 58'h12_3456_ABCD;
  localparam logic [57:0] REM_A = {12'hABC, 46'h3FFF_0000_1111};

  initial begin
    logic [31:0] d;
    rstN = 0; tableClr = 0; regWe = 0; regAddr = 0; regWdata = 0;
    arReqValid = 0; arReqAddr = 0; arReqId = 0; arFwdReady = 1;
    awReqValid = 0; awReqAddr = 0; awReqId = 0; awFwdReady = 1;
    gRegWe = 0; gRegAddr = 0; gRegWdata = 0; gArValid = 0;
    modelClear(); mRdMiss = 0; mWrMiss = 0; mArProt = 3'b010; mAwProt = 3'b010;
    mSa = 0; mSb = 0;
    for (int b = 0; b < 5; b++) mBuf[b] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1; running = 1;

    // reset state: privileged
    curReq = "R9";
    regRd(4'd0, d); chk(d == 32'h0, "R6", "priv miss reset", {224'h0, d}, 256'h0);
    regRd(4'd1, d); chk(d == 32'h22, "R10", "priv prot reset", {224'h0, d}, 256'h22);
    chk(arFwdProt == 3'b010 && awFwdProt == 3'b010, "R10", "prot pins", {250'h0, arFwdProt, awFwdProt}, 256'h12);
    readEntry(0, "R9");
    // reset state: guest
    gRd(4'd0, d); chk(d == 32'h3, "R6", "guest miss reset", {224'h0, d}, 256'h3);
    gRd(4'd5, d); chk(d == 32'h1000_0000, "R9", "guest entry idDis reset", {224'h0, d}, 256'h1000_0000);
    @(posedge clk); #1 gRegWe = 1; gRegAddr = 4'd1; gRegWdata = 32'h77;
    @(posedge clk); #1 gRegWe = 0;
    gRd(4'd1, d); chk(d == 32'h0, "R10", "guest prot ignored", {224'h0, d}, 256'h0);
    chk(gArProt == 3'h0 && gAwProt == 3'h0, "R10", "guest prot pins", {250'h0, gArProt, gAwProt}, 256'h0);
    @(posedge clk); #1 gArValid = 1;
    @(negedge clk);
    chk(gArFwdValid == 1'b1 && gArFwdAddr == 58'h3_0000_1000, "R6", "guest miss passes",
        {197'h0, gArFwdValid, gArFwdAddr}, {197'h0, 1'b1, 58'h3_0000_1000});
    @(posedge clk); #1 gArValid = 0;

    // miss policy
    curReq = "R6";
    ar(1, 58'h5_0000_0040, 10'h1, 3);
    aw(1, 58'h5_0000_0080, 10'h1, 3);
    regWr(4'd0, 32'h2);
    ar(1, 58'h5_0000_0040, 10'h1, 2);
    aw(1, 58'h5_0000_0080, 10'h1, 2);
    regWr(4'd0, 32'h0);

    // match rule and per-direction verdict
    curReq = "R1";
    prog(2, 6'b101000, 58'h12_3456_0000, 58'hFFFF, 46'h0, 10'h155);
    ar(1, HIT_A, 10'h155, 2);
    ar(1, HIT_A, 10'h154, 2);
    ar(1, 58'h12_3457_0000, 10'h155, 2);
    curReq = "R3";
    aw(1, HIT_A, 10'h155, 2);
    arFwdReady = 0;
    ar(1, HIT_A, 10'h155, 2);
    arFwdReady = 1;

    // priority
    curReq = "R2";
    prog(1, 6'b110100, 58'h12_3400_0000, 58'hFF_FFFF, 46'h0, 10'h0);
    ar(1, HIT_A, 10'h155, 2);
    aw(1, HIT_A, 10'h2AA, 2);

    // remap
    curReq = "R4";
    prog(0, 6'b111101, {12'hABC, 46'h0}, {12'h0, {46{1'b1}}}, 46'h1234_5678_9ABC, 10'h0);
    ar(1, REM_A, 10'h9, 2);
    aw(1, REM_A, 10'h9, 2);

    // interleave swap
    curReq = "R5";
    regWr(4'd2, {18'h0, 6'd0, 2'b0, 6'd57});
    prog(0, 6'b111111, {12'hABC, 46'h0}, {12'h0, {46{1'b1}}}, 46'h1234_5678_9ABC, 10'h0);
    ar(1, REM_A, 10'h9, 2);
    regWr(4'd2, {18'h0, 6'd3, 2'b0, 6'd60});
    aw(1, REM_A, 10'h9, 2);

    // read window
    readEntry(2, "R7");
    readEntry(1, "R7");
    readEntry(100, "R7");

    // commit, out of range index ignored
    curReq = "R8";
    prog(15, 6'b111100, 58'h7_0000_0000, 58'hFFF, 46'h0, 10'h0);
    readEntry(15, "R8");
    prog(200, 6'b111100, 58'h9_0000_0000, 58'hFFF, 46'h0, 10'h0);
    ar(1, 58'h9_0000_0010, 10'h0, 2);
    ar(1, 58'h7_0000_0010, 10'h0, 2);

    // protection register
    curReq = "R10";
    regWr(4'd1, 32'h51);
    ar(1, HIT_A, 10'h155, 1);
    aw(1, REM_A, 10'h2, 1);

    // simultaneous denial, read address wins
    curReq = "R11";
    @(posedge clk); #1
    arReqValid = 1; arReqAddr = 58'h8_0000_0100; arReqId = 10'h1;
    awReqValid = 1; awReqAddr = 58'h8_0000_0200; awReqId = 10'h1;
    arFwdReady = 0;
    @(posedge clk); #1 arReqValid = 0;
    repeat (2) @(posedge clk);
    #1 awReqValid = 0; arFwdReady = 1;
    repeat (2) @(posedge clk);

    // clear
    curReq = "R12";
    @(posedge clk); #1 tableClr = 1;
    @(posedge clk); #1 tableClr = 0; modelClear();
    readEntry(2, "R12");
    regRd(4'd1, d); chk(d == 32'h51, "R12", "prot kept across clear", {224'h0, d}, 256'h51);
    ar(1, HIT_A, 10'h155, 2);
    aw(1, REM_A, 10'h9, 2);

    running = 0; done = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule